// File: doc/BRIEF.md
# Block-Mode DMA Ready Flag Generator

This block produces the transmit-ready and receive-ready DMA request pins of a UART whose transmit and receive FIFOs each hold 64 entries. It is used when block transfer DMA mode is selected. It takes the FIFO occupancy counts, two programmable trigger levels, a receive timeout event and a flag that reports an error held in the receive FIFO. From these it keeps one latched request per direction.

Each request uses hysteresis. The transmit request turns on once enough free locations exist, and stays on until the transmit FIFO is completely full. The receive request turns on when the fill level reaches its trigger, or when a receive timeout occurs. It stays on until the receive FIFO drains to empty or an error is flagged in it. Between its set and clear conditions, each request keeps its previous value. Both pins are active low and registered on the UART clock. The block holds both pins inactive when the FIFOs are disabled or block mode is not selected.

Top module: `dma_ready_gen`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both `txRdyN` and `rxRdyN` are 1 (inactive).
- R2: In block mode, when the free transmit space (64 minus `txCount`) is at least `txTrig` and the FIFO is not full, `txRdyN` is 0 after the next rising clock edge.
- R3: When the transmit set and clear conditions are both false, `txRdyN` keeps its previous value.
- R4: When `txCount` equals 64, `txRdyN` is 1 after the next edge. This clear takes priority over a simultaneous set, including when `txTrig` is 0.
- R5: When `rxCount` is nonzero and at least `rxTrig`, `rxRdyN` is 0 after the next edge.
- R6: A one-cycle `rxTimeout` pulse with a nonzero `rxCount` below the trigger drives `rxRdyN` to 0 after the next edge, and the request stays on after the pulse ends.
- R7: When `rxCount` is 0, `rxRdyN` is 1 after the next edge. Above zero and below the trigger, with no timeout and no error, it holds its value.
- R8: When `rxFifoErr` is 1, `rxRdyN` is 1 after the next edge. This clear takes priority over trigger and timeout set conditions.
- R9: When `fifoEnable` is 0 or `dmaBlockMode` is 0, both pins are 1 after the next edge. When both inputs return to 1, the conditions are evaluated again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEnable | input | 1 | FIFOs enabled |
| dmaBlockMode | input | 1 | 1 selects block transfer DMA mode |
| txCount | input | 7 | Transmit FIFO occupancy, 0 to 64 |
| txTrig | input | 7 | Transmit trigger, in free locations |
| rxCount | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rxTrig | input | 7 | Receive trigger, in filled locations |
| rxTimeout | input | 1 | Receive timeout interrupt event |
| rxFifoErr | input | 1 | An entry in the receive FIFO carries an error |
| txRdyN | output | 1 | Transmit DMA request, active low |
| rxRdyN | output | 1 | Receive DMA request, active low |

## Verification
The occupancy sequences cross each threshold in both directions. This separates a latched request, which must hold in the band between its set and clear points, from a plain level comparison, which would drop as soon as the count falls back below the trigger. The receive path is driven with a timeout below the trigger, and then with error and timeout together, to show which cause sets the request and which cause wins when they conflict. A full transmit FIFO with a zero trigger, and an empty one with a trigger of 64, test both ends of the transmit comparison. Toggling the mode inputs and pulsing reset while the requests are on shows that both pins are forced inactive.

// File: rtl/dma_ready_pkg.sv
package dma_ready_pkg;
  // Strobes from the control decoder to the flag datapath
  typedef struct packed {
    logic modeIdle;
    logic txSet;
    logic txClr;
    logic rxSet;
    logic rxClr;
  } flagStrobes_t;
endpackage

// File: rtl/dma_ready_ctrl.sv
module dma_ready_ctrl
  import dma_ready_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             fifoEnable,
  input  logic             dmaBlockMode,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] txTrig,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic             rxTimeout,
  input  logic             rxFifoErr,
  output flagStrobes_t     strobes
);
  localparam logic [CNT_W-1:0] FullLevel = CNT_W'(DEPTH);

  logic [CNT_W-1:0] txFree;
  logic             txFull;
  logic             rxEmpty;
  logic             rxAtTrig;

  always_comb begin
    txFree   = FullLevel - txCount;
    txFull   = (txCount == FullLevel);
    rxEmpty  = (rxCount == '0);
    rxAtTrig = (rxCount >= rxTrig) && !rxEmpty;

    strobes.modeIdle = !(fifoEnable && dmaBlockMode);
    strobes.txSet    = (txFree >= txTrig);
    strobes.txClr    = txFull;
    strobes.rxSet    = rxAtTrig || rxTimeout;
    strobes.rxClr    = rxEmpty || rxFifoErr;
  end
endmodule

// File: rtl/dma_ready_dp.sv
module dma_ready_dp
  import dma_ready_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  flagStrobes_t strobes,
  output logic         txRdyN,
  output logic         rxRdyN
);
  logic txFlag;
  logic rxFlag;
  logic txNext;
  logic rxNext;

  // Set/reset latch per direction; clear dominates, mode idle dominates all
  always_comb begin
    txNext = txFlag;
    rxNext = rxFlag;
    if (strobes.txSet) txNext = 1'b1;
    if (strobes.txClr) txNext = 1'b0;
    if (strobes.rxSet) rxNext = 1'b1;
    if (strobes.rxClr) rxNext = 1'b0;
    if (strobes.modeIdle) begin
      txNext = 1'b0;
      rxNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFlag <= 1'b0;
      rxFlag <= 1'b0;
    end else begin
      txFlag <= txNext;
      rxFlag <= rxNext;
    end
  end

  assign txRdyN = ~txFlag;
  assign rxRdyN = ~rxFlag;
endmodule

// File: rtl/dma_ready_gen.sv
module dma_ready_gen
  import dma_ready_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEnable,
  input  logic             dmaBlockMode,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] txTrig,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] rxTrig,
  input  logic             rxTimeout,
  input  logic             rxFifoErr,
  output logic             txRdyN,
  output logic             rxRdyN
);
  flagStrobes_t strobes;

  dma_ready_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .fifoEnable  (fifoEnable),
    .dmaBlockMode(dmaBlockMode),
    .txCount     (txCount),
    .txTrig      (txTrig),
    .rxCount     (rxCount),
    .rxTrig      (rxTrig),
    .rxTimeout   (rxTimeout),
    .rxFifoErr   (rxFifoErr),
    .strobes     (strobes)
  );

  dma_ready_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .txRdyN (txRdyN),
    .rxRdyN (rxRdyN)
  );
endmodule

// File: rtl/dma_ready_gen_chk.sv
module dma_ready_gen_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEnable,
  input logic             dmaBlockMode,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] txTrig,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] rxTrig,
  input logic             rxTimeout,
  input logic             rxFifoErr,
  input logic             txRdyN,
  input logic             rxRdyN
);
  localparam logic [CNT_W-1:0] Full = CNT_W'(DEPTH);
  logic active;
  assign active = fifoEnable && dmaBlockMode;

  p_reset_idle_r1: assert property (@(posedge clk) !rstN |-> (txRdyN && rxRdyN));

  p_tx_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (active && (txCount != Full) && ((Full - txCount) >= txTrig)) |=> !txRdyN);

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && (txCount != Full) && ((Full - txCount) < txTrig)) |=> $stable(txRdyN));

  p_tx_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == Full) |=> txRdyN);

  p_rx_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (active && !rxFifoErr && (rxCount != 0) && (rxCount >= rxTrig)) |=> !rxRdyN);

  p_rx_timeout_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !rxFifoErr && (rxCount != 0) && rxTimeout) |=> !rxRdyN);

  p_rx_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == 0) |=> rxRdyN);

  p_rx_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoErr |=> rxRdyN);

  p_mode_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (txRdyN && rxRdyN));
endmodule

bind dma_ready_gen dma_ready_gen_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .dmaBlockMode(dmaBlockMode),
  .txCount(txCount), .txTrig(txTrig), .rxCount(rxCount), .rxTrig(rxTrig),
  .rxTimeout(rxTimeout), .rxFifoErr(rxFifoErr), .txRdyN(txRdyN), .rxRdyN(rxRdyN)
);

// File: tb/dma_ready_gen_tb.sv
module dma_ready_gen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoEnable = 1'b0, dmaBlockMode = 1'b0;
  logic [6:0] txCount = '0, txTrig = '0, rxCount = '0, rxTrig = '0;
  logic rxTimeout = 1'b0, rxFifoErr = 1'b0;
  logic txRdyN, rxRdyN;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  dma_ready_gen u_dut (
    .clk(clk), .rstN(rstN), .fifoEnable(fifoEnable), .dmaBlockMode(dmaBlockMode),
    .txCount(txCount), .txTrig(txTrig), .rxCount(rxCount), .rxTrig(rxTrig),
    .rxTimeout(rxTimeout), .rxFifoErr(rxFifoErr), .txRdyN(txRdyN), .rxRdyN(rxRdyN)
  );

  // {en, blk, txCount, txTrig, rxCount, rxTrig, tmo, err, expTxN, expRxN, req}
  localparam int NV = 18;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,1'b1,7'd60,7'd16,7'd0 ,7'd8,1'b0,1'b0,1'b1,1'b1,4'd3}, // R3 free 4 < 16, R7 empty
    {1'b1,1'b1,7'd48,7'd16,7'd3 ,7'd8,1'b0,1'b0,1'b0,1'b1,4'd2}, // R2 free 16 reaches trig
    {1'b1,1'b1,7'd55,7'd16,7'd5 ,7'd8,1'b0,1'b0,1'b0,1'b1,4'd3}, // R3 hold on
    {1'b1,1'b1,7'd64,7'd16,7'd5 ,7'd8,1'b0,1'b0,1'b1,1'b1,4'd4}, // R4 full releases
    {1'b1,1'b1,7'd50,7'd16,7'd5 ,7'd8,1'b0,1'b0,1'b1,1'b1,4'd3}, // R3 hold off
    {1'b1,1'b1,7'd40,7'd16,7'd8 ,7'd8,1'b0,1'b0,1'b0,1'b0,4'd5}, // R5 rx at trig
    {1'b1,1'b1,7'd40,7'd16,7'd4 ,7'd8,1'b0,1'b0,1'b0,1'b0,4'd7}, // R7 hold on
    {1'b1,1'b1,7'd40,7'd16,7'd0 ,7'd8,1'b0,1'b0,1'b0,1'b1,4'd7}, // R7 empty
    {1'b1,1'b1,7'd40,7'd16,7'd3 ,7'd8,1'b1,1'b0,1'b0,1'b0,4'd6}, // R6 timeout
    {1'b1,1'b1,7'd40,7'd16,7'd3 ,7'd8,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 held
    {1'b1,1'b1,7'd40,7'd16,7'd10,7'd8,1'b0,1'b1,1'b0,1'b1,4'd8}, // R8 error clears
    {1'b1,1'b1,7'd40,7'd16,7'd10,7'd8,1'b0,1'b0,1'b0,1'b0,4'd5}, // R5 set again
    {1'b1,1'b1,7'd40,7'd16,7'd10,7'd8,1'b1,1'b1,1'b0,1'b1,4'd8}, // R8 wins over tmo
    {1'b0,1'b1,7'd40,7'd16,7'd10,7'd8,1'b0,1'b0,1'b1,1'b1,4'd9}, // R9 fifo off
    {1'b1,1'b0,7'd40,7'd16,7'd10,7'd8,1'b0,1'b0,1'b1,1'b1,4'd9}, // R9 single mode
    {1'b1,1'b1,7'd40,7'd16,7'd10,7'd8,1'b0,1'b0,1'b0,1'b0,4'd9}, // R9 re-enable
    {1'b1,1'b1,7'd64,7'd0 ,7'd10,7'd8,1'b0,1'b0,1'b1,1'b0,4'd4}, // R4 full, trig 0
    {1'b1,1'b1,7'd0 ,7'd64,7'd1 ,7'd1,1'b0,1'b0,1'b0,1'b0,4'd2}  // R2 empty, trig 64
  };

  task automatic check(input logic act, input logic exp, input string what, input int req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R0 watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check(txRdyN, 1'b1, "reset txRdyN", 1);
    check(rxRdyN, 1'b1, "reset rxRdyN", 1);
    fifoEnable = 1'b1; dmaBlockMode = 1'b1;
    txCount = 7'd60; txTrig = 7'd16; rxCount = 7'd0; rxTrig = 7'd8;
    rstN = 1'b1;
    @(negedge clk);
    check(txRdyN, 1'b1, "R1 first edge tx", 1);
    check(rxRdyN, 1'b1, "R1 first edge rx", 1);

    for (int i = 0; i < NV; i++) begin
      {fifoEnable, dmaBlockMode, txCount, txTrig, rxCount, rxTrig, rxTimeout, rxFifoErr} = VEC[i][37:6];
      @(negedge clk);
      check(txRdyN, VEC[i][5], $sformatf("vec %0d txRdyN", i), int'(VEC[i][3:0]));
      check(rxRdyN, VEC[i][4], $sformatf("vec %0d rxRdyN", i), int'(VEC[i][3:0]));
    end

    // R1: reset while both requests are on
    check(txRdyN, 1'b0, "R1 pre-reset tx on", 1);
    rstN = 1'b0;
    #1;
    check(txRdyN, 1'b1, "R1 async reset tx", 1);
    check(rxRdyN, 1'b1, "R1 async reset rx", 1);
    @(negedge clk);
    rstN = 1'b1;
    // R6: timeout with count 0 is overridden by empty (R7)
    txCount = 7'd64; rxCount = 7'd0; rxTimeout = 1'b1;
    @(negedge clk);
    check(rxRdyN, 1'b1, "R7 empty beats timeout", 7);
    check(txRdyN, 1'b1, "R4 full after reset", 4);
    rxTimeout = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule